// File: doc/BRIEF.md
# Snooping MESI Cache Coherence Controller

This block sits beside one small direct-mapped write-back cache in a shared-bus multiprocessor and keeps that cache coherent with its peers. Every line carries one of four coherence states: Invalid, Shared, Exclusive (clean, held only here) or Modified (dirty, held only here). Processor reads and writes that hit in a suitable state finish locally. Anything else makes the controller ask a single-owner bus arbiter for the bus, broadcast a command, and collect the replies from the other caches.

Bus ownership is the only thing that orders writes. A controller that broadcasts a write miss or an invalidate keeps its request raised until every other cache has acknowledged. The controller also watches commands from other caches. It reports when it holds the snooped line. When its copy is dirty on a read, it hands the data over in place of memory; memory captures that same transfer. It drops its copy when another cache wants to write. Each line holds one data word. The memory port is a simple word request/acknowledge interface.

Top module: `mesi_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid: `cpu_ready` is high, `bus_req`, `mem_req` and `cpu_resp_valid` are low, and no snoop reports a hit.
- R2: A processor read that hits a valid line with a matching tag returns the stored word on `cpu_resp_rdata` with `cpu_resp_valid` one cycle after acceptance, and issues no bus command and no memory access.
- R3: A processor read miss issues bus command 1 (read). If `bus_dirty_in` is high in the command cycle, the word on `bus_data_in` fills the line as Shared and memory is not read. Otherwise the word is read from memory, and the line fills as Shared if `bus_shared_in` was high in the command cycle, or as Exclusive if it was low.
- R4: A processor write to an Exclusive or Modified line updates the word and leaves the line Modified, with no bus command.
- R5: A processor write to a Shared line requests the bus and issues command 3 (invalidate) only in a cycle where `bus_gnt` is high; afterwards the line is Modified with the new word.
- R6: A processor write miss issues command 2 (read-for-ownership) and installs the written word as Modified, without a memory read.
- R7: After issuing command 2 or 3, `bus_req` stays high until `inv_ack_all` has been seen.
- R8: A miss whose victim line is Modified first writes the victim word to memory at the victim's address, before requesting the bus; a clean victim causes no memory write.
- R9: A snooped read (`snp_cmd` = 1) that hits raises `snp_shared`. If the line is Modified, `snp_supply` is raised and `snp_data` carries the word. An Exclusive or Modified line becomes Shared, so a later local write needs an invalidate.
- R10: A snooped command 2 or 3 that hits a line in any valid state makes it Invalid and never raises `snp_supply`.
- R11: A snoop whose tag differs from the tag stored at its index does not change that line or raise `snp_shared`.
- R12: If a snooped invalidate takes away a Shared line while its own upgrade waits for the bus, the controller issues command 2 instead of command 3 once granted.
- R13: `cpu_ready` is low while a processor operation is in progress and in any cycle with `snp_valid` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_we | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | AW | Word address |
| cpu_req_wdata | input | DW | Write data |
| cpu_ready | output | 1 | Request accepted in this cycle if valid |
| cpu_resp_valid | output | 1 | One-cycle completion pulse |
| cpu_resp_rdata | output | DW | Read data |
| bus_req | output | 1 | Bus request, held for the whole tenure |
| bus_gnt | input | 1 | Bus grant from arbiter |
| bus_valid | output | 1 | Command driven on the bus this cycle |
| bus_cmd | output | 2 | 1 read, 2 read-for-ownership, 3 invalidate |
| bus_addr | output | AW | Command address |
| bus_shared_in | input | 1 | Another cache holds the line |
| bus_dirty_in | input | 1 | Another cache supplies dirty data |
| bus_data_in | input | DW | Data supplied by another cache |
| inv_ack_all | input | 1 | All other caches acknowledged |
| snp_valid | input | 1 | Snooped command present |
| snp_cmd | input | 2 | Snooped command, same encoding |
| snp_addr | input | AW | Snooped address |
| snp_shared | output | 1 | Snoop hit a valid line |
| snp_supply | output | 1 | Dirty data supplied |
| snp_data | output | DW | Supplied data |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write-back, 0 = fill read |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Write-back data |
| mem_rdata | input | DW | Fill data |
| mem_ack | input | 1 | Memory access done |

## Verification
The assertions watch, cycle by cycle, the rules that show directly at the ports. A command is driven only under grant, and is never command 0. The bus request stays up between an ownership or invalidate command and the acknowledge. A write-back happens outside bus tenure and a fill read inside it. Dirty data is supplied only on read snoops and always with the hit flag. The coherence state itself is hidden, so only the bench's scenarios can show whether a fill landed as Exclusive or Shared, whether a write upgraded silently, whether an eviction carried the right word, and whether a lost upgrade turned into a read-for-ownership. The bench shows these through the bus command and memory traffic of later operations, checked against a reference model.

// File: rtl/mesi_pkg.sv
package mesi_pkg;
    typedef enum logic [1:0] {
        LS_I = 2'd0,
        LS_S = 2'd1,
        LS_E = 2'd2,
        LS_M = 2'd3
    } line_st_e;

    typedef enum logic [1:0] {
        BC_NONE = 2'd0,
        BC_RD   = 2'd1,
        BC_RDX  = 2'd2,
        BC_UPG  = 2'd3
    } bus_cmd_e;

    typedef enum logic [2:0] {
        F_IDLE,
        F_WB,
        F_ARB,
        F_ISSUE,
        F_INVW,
        F_FILL
    } fsm_e;
endpackage

// File: rtl/mesi_tag_match.sv
module mesi_tag_match
    import mesi_pkg::*;
#(
    parameter int TW = 5
) (
    input  logic [1:0]    line_st,
    input  logic [TW-1:0] line_tag,
    input  logic [TW-1:0] probe_tag,
    output logic          hit
);
    assign hit = (line_st != LS_I) && (line_tag == probe_tag);
endmodule

// File: rtl/mesi_snoop_xfer.sv
module mesi_snoop_xfer
    import mesi_pkg::*;
(
    input  logic       accept,
    input  logic       hit,
    input  logic [1:0] cur_st,
    input  logic [1:0] cmd,
    output logic [1:0] nxt_st,
    output logic       upd,
    output logic       shared,
    output logic       supply
);
    always_comb begin
        nxt_st = cur_st;
        upd    = 1'b0;
        shared = 1'b0;
        supply = 1'b0;
        if (accept && hit) begin
            shared = 1'b1;
            case (cmd)
                BC_RD: begin
                    supply = (cur_st == LS_M);
                    if (cur_st == LS_E || cur_st == LS_M) begin
                        nxt_st = LS_S;
                        upd    = 1'b1;
                    end
                end
                BC_RDX, BC_UPG: begin
                    nxt_st = LS_I;
                    upd    = 1'b1;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/mesi_snoop_ctrl.sv
module mesi_snoop_ctrl
    import mesi_pkg::*;
#(
    parameter int AW    = 8,
    parameter int DW    = 32,
    parameter int LINES = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cpu_req_valid,
    input  logic          cpu_req_we,
    input  logic [AW-1:0] cpu_req_addr,
    input  logic [DW-1:0] cpu_req_wdata,
    output logic          cpu_ready,
    output logic          cpu_resp_valid,
    output logic [DW-1:0] cpu_resp_rdata,
    output logic          bus_req,
    input  logic          bus_gnt,
    output logic          bus_valid,
    output logic [1:0]    bus_cmd,
    output logic [AW-1:0] bus_addr,
    input  logic          bus_shared_in,
    input  logic          bus_dirty_in,
    input  logic [DW-1:0] bus_data_in,
    input  logic          inv_ack_all,
    input  logic          snp_valid,
    input  logic [1:0]    snp_cmd,
    input  logic [AW-1:0] snp_addr,
    output logic          snp_shared,
    output logic          snp_supply,
    output logic [DW-1:0] snp_data,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_ack
);
    localparam int IW = $clog2(LINES);
    localparam int TW = AW - IW;

    typedef struct packed {
        fsm_e                   fsm;
        logic [LINES-1:0][1:0]  st;
        logic [LINES-1:0][TW-1:0] tag;
        logic [LINES-1:0][DW-1:0] dat;
        logic                   we;
        logic [AW-1:0]          addr;
        logic [DW-1:0]          wdata;
        logic [1:0]             cmd;
        logic                   shared_seen;
        logic                   resp_v;
        logic [DW-1:0]          resp_d;
    } regs_t;

    regs_t q, d;

    logic [IW-1:0] req_idx, own_idx, snp_idx;
    logic [TW-1:0] req_tag, own_tag, snp_tag;
    logic          req_hit, own_hit, snp_hit, snp_accept, snp_upd;
    logic [1:0]    snp_nxt;

    assign req_idx = cpu_req_addr[IW-1:0];
    assign req_tag = cpu_req_addr[AW-1:IW];
    assign own_idx = q.addr[IW-1:0];
    assign own_tag = q.addr[AW-1:IW];
    assign snp_idx = snp_addr[IW-1:0];
    assign snp_tag = snp_addr[AW-1:IW];

    mesi_tag_match #(.TW(TW)) req_lu_i (
        .line_st(q.st[req_idx]), .line_tag(q.tag[req_idx]),
        .probe_tag(req_tag), .hit(req_hit));
    mesi_tag_match #(.TW(TW)) own_lu_i (
        .line_st(q.st[own_idx]), .line_tag(q.tag[own_idx]),
        .probe_tag(own_tag), .hit(own_hit));
    mesi_tag_match #(.TW(TW)) snp_lu_i (
        .line_st(q.st[snp_idx]), .line_tag(q.tag[snp_idx]),
        .probe_tag(snp_tag), .hit(snp_hit));

    // Snoops are served only while this controller does not own the bus.
    assign snp_accept = snp_valid &&
                        (q.fsm == F_IDLE || q.fsm == F_WB || q.fsm == F_ARB);

    mesi_snoop_xfer snp_xfer_i (
        .accept(snp_accept), .hit(snp_hit), .cur_st(q.st[snp_idx]),
        .cmd(snp_cmd), .nxt_st(snp_nxt), .upd(snp_upd),
        .shared(snp_shared), .supply(snp_supply));

    assign snp_data       = q.dat[snp_idx];
    assign cpu_ready      = (q.fsm == F_IDLE) && !snp_valid;
    assign cpu_resp_valid = q.resp_v;
    assign cpu_resp_rdata = q.resp_d;
    assign bus_req        = (q.fsm == F_ARB) || (q.fsm == F_ISSUE) ||
                            (q.fsm == F_INVW) || (q.fsm == F_FILL);
    assign bus_valid      = (q.fsm == F_ISSUE);
    assign bus_cmd        = (q.fsm == F_ISSUE) ? q.cmd : 2'b00;
    assign bus_addr       = q.addr;
    assign mem_req        = (q.fsm == F_WB) || (q.fsm == F_FILL);
    assign mem_we         = (q.fsm == F_WB);
    assign mem_addr       = (q.fsm == F_WB) ? {q.tag[own_idx], own_idx} : q.addr;
    assign mem_wdata      = q.dat[own_idx];

    always_comb begin
        d        = q;
        d.resp_v = 1'b0;
        if (snp_upd) d.st[snp_idx] = snp_nxt;
        case (q.fsm)
            F_IDLE: begin
                if (cpu_req_valid && cpu_ready) begin
                    d.we    = cpu_req_we;
                    d.addr  = cpu_req_addr;
                    d.wdata = cpu_req_wdata;
                    if (req_hit && !cpu_req_we) begin
                        d.resp_v = 1'b1;
                        d.resp_d = q.dat[req_idx];
                    end else if (req_hit && q.st[req_idx] != LS_S) begin
                        d.st[req_idx]  = LS_M;
                        d.dat[req_idx] = cpu_req_wdata;
                        d.resp_v       = 1'b1;
                        d.resp_d       = cpu_req_wdata;
                    end else if (req_hit) begin
                        d.cmd = BC_UPG;
                        d.fsm = F_ARB;
                    end else begin
                        d.cmd = cpu_req_we ? BC_RDX : BC_RD;
                        d.fsm = (q.st[req_idx] == LS_M) ? F_WB : F_ARB;
                    end
                end
            end
            F_WB: begin
                if (mem_ack) begin
                    d.st[own_idx] = LS_I;
                    d.fsm         = F_ARB;
                end
            end
            F_ARB: begin
                if (bus_gnt) begin
                    d.fsm = F_ISSUE;
                    if (q.cmd == BC_UPG && !own_hit) d.cmd = BC_RDX;
                end
            end
            F_ISSUE: begin
                if (q.cmd != BC_RD) begin
                    d.fsm = F_INVW;
                end else if (bus_dirty_in) begin
                    d.st[own_idx]  = LS_S;
                    d.tag[own_idx] = own_tag;
                    d.dat[own_idx] = bus_data_in;
                    d.resp_v       = 1'b1;
                    d.resp_d       = bus_data_in;
                    d.fsm          = F_IDLE;
                end else begin
                    d.shared_seen = bus_shared_in;
                    d.fsm         = F_FILL;
                end
            end
            F_INVW: begin
                if (inv_ack_all) begin
                    d.st[own_idx]  = LS_M;
                    d.tag[own_idx] = own_tag;
                    d.dat[own_idx] = q.wdata;
                    d.resp_v       = 1'b1;
                    d.resp_d       = q.wdata;
                    d.fsm          = F_IDLE;
                end
            end
            F_FILL: begin
                if (mem_ack) begin
                    d.st[own_idx]  = q.shared_seen ? LS_S : LS_E;
                    d.tag[own_idx] = own_tag;
                    d.dat[own_idx] = mem_rdata;
                    d.resp_v       = 1'b1;
                    d.resp_d       = mem_rdata;
                    d.fsm          = F_IDLE;
                end
            end
            default: d.fsm = F_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/mesi_snoop_ctrl_chk.sv
module mesi_snoop_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_req,
    input logic       bus_gnt,
    input logic       bus_valid,
    input logic [1:0] bus_cmd,
    input logic       inv_ack_all,
    input logic       mem_req,
    input logic       mem_we,
    input logic       snp_valid,
    input logic [1:0] snp_cmd,
    input logic       snp_shared,
    input logic       snp_supply
);
    logic inv_pend;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                               inv_pend <= 1'b0;
        else if (bus_valid && (bus_cmd == 2'd2 || bus_cmd == 2'd3)) inv_pend <= 1'b1;
        else if (inv_ack_all)                                     inv_pend <= 1'b0;
    end

    a_r5_issue_under_grant: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |-> bus_gnt);
    a_r5_cmd_not_idle: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |-> (bus_cmd != 2'd0));
    a_r7_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
        inv_pend |-> bus_req);
    a_r8_wb_outside_tenure: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> !bus_req);
    a_r3_fill_inside_tenure: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |-> bus_req);
    a_r9_supply_with_hit: assert property (@(posedge clk) disable iff (!rst_n)
        snp_supply |-> snp_shared);
    a_r10_no_supply_on_inval: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && snp_cmd != 2'd1) |-> !snp_supply);
endmodule

bind mesi_snoop_ctrl mesi_snoop_ctrl_chk chk_i (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_gnt(bus_gnt),
    .bus_valid(bus_valid), .bus_cmd(bus_cmd), .inv_ack_all(inv_ack_all),
    .mem_req(mem_req), .mem_we(mem_we), .snp_valid(snp_valid),
    .snp_cmd(snp_cmd), .snp_shared(snp_shared), .snp_supply(snp_supply));

// File: tb/mesi_snoop_ctrl_tb_top.sv
`timescale 1ns/1ps
module mesi_snoop_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req_valid = 0, cpu_req_we = 0;
    logic [7:0]  cpu_req_addr = 0;
    logic [31:0] cpu_req_wdata = 0;
    logic        cpu_ready, cpu_resp_valid;
    logic [31:0] cpu_resp_rdata;
    logic        bus_req, bus_valid;
    logic        bus_gnt = 0, bus_shared_in = 0, bus_dirty_in = 0, inv_ack_all = 0;
    logic [1:0]  bus_cmd;
    logic [7:0]  bus_addr;
    logic [31:0] bus_data_in = 0;
    logic        snp_valid = 0;
    logic [1:0]  snp_cmd = 0;
    logic [7:0]  snp_addr = 0;
    logic        snp_shared, snp_supply;
    logic [31:0] snp_data;
    logic        mem_req, mem_we;
    logic [7:0]  mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = 0;
    logic        mem_ack = 0;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    int          m_st [8];
    logic [4:0]  m_tag[8];
    logic [31:0] m_dat[8];
    logic [31:0] mem  [256];

    always #4 clk = ~clk;

    mesi_snoop_ctrl dut_i (.*);

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic snoop_op(input int cmd, input logic [7:0] a, input string ov);
        int idx;
        bit hit, esup;
        string rq;
        idx  = int'(a[2:0]);
        hit  = (m_st[idx] != 0) && (m_tag[idx] == a[7:3]);
        esup = hit && (m_st[idx] == 3) && (cmd == 1);
        rq   = (m_st[idx] != 0 && !hit) ? "R11" : ((cmd == 1) ? "R9" : "R10");
        if (ov != "") rq = ov;
        @(negedge clk);
        snp_valid = 1; snp_cmd = 2'(cmd); snp_addr = a;
        #2;
        chk(snp_shared == hit, rq, 32'(snp_shared), 32'(hit));
        chk(snp_supply == esup, rq, 32'(snp_supply), 32'(esup));
        if (esup) chk(snp_data == m_dat[idx], "R9", snp_data, m_dat[idx]);
        chk(!cpu_ready, "R13", 32'(cpu_ready), 0);
        if (hit) begin
            if (cmd == 1) begin
                if (m_st[idx] == 3) mem[a] = m_dat[idx];
                m_st[idx] = 1;
            end else begin
                m_st[idx] = 0;
            end
        end
        @(negedge clk);
        snp_valid = 0;
    endtask

    task automatic cpu_op(input bit we, input logic [7:0] a, input logic [31:0] wd,
                          input bit shr, input bit drt, input logic [31:0] ddat, input bit race);
        int idx, ecmd, emrd, scmd, smrd, invc;
        bit hit, ewb, swb, sv, raced, done;
        logic [7:0]  ewb_a, swb_a;
        logic [31:0] ewb_d, swb_d, erd, srd;
        string rq;
        idx = int'(a[2:0]);
        hit = (m_st[idx] != 0) && (m_tag[idx] == a[7:3]);
        ecmd = 0; emrd = 0; ewb = 0; ewb_a = 0; ewb_d = 0; erd = 0;
        if (hit && !we) begin
            rq = "R2"; erd = m_dat[idx];
        end else if (hit && m_st[idx] >= 2) begin
            rq = "R4"; m_st[idx] = 3; m_dat[idx] = wd;
        end else if (hit) begin
            rq = race ? "R12" : "R5"; ecmd = race ? 2 : 3;
            m_st[idx] = 3; m_dat[idx] = wd;
        end else begin
            if (m_st[idx] == 3) begin
                ewb = 1; ewb_a = {m_tag[idx], a[2:0]}; ewb_d = m_dat[idx];
                mem[ewb_a] = ewb_d;
            end
            m_tag[idx] = a[7:3];
            if (we) begin
                rq = "R6"; ecmd = 2; m_st[idx] = 3; m_dat[idx] = wd;
            end else begin
                rq = "R3"; ecmd = 1;
                if (drt) begin
                    m_dat[idx] = ddat; mem[a] = ddat; m_st[idx] = 1;
                end else begin
                    emrd = 1; m_dat[idx] = mem[a]; m_st[idx] = shr ? 1 : 2;
                end
                erd = m_dat[idx];
            end
        end
        @(negedge clk);
        bus_shared_in = shr; bus_dirty_in = drt; bus_data_in = ddat;
        cpu_req_valid = 1; cpu_req_we = we; cpu_req_addr = a; cpu_req_wdata = wd;
        @(negedge clk);
        cpu_req_valid = 0;
        scmd = 0; smrd = 0; swb = 0; swb_a = 0; swb_d = 0; srd = 0;
        sv = 0; raced = 0; done = 0; invc = 0;
        for (int n = 0; n < 200; n++) begin
            snp_valid = 0;
            if (cpu_resp_valid) begin
                srd = cpu_resp_rdata; done = 1;
                break;
            end
            if (n == 0) chk(!cpu_ready, "R13", 32'(cpu_ready), 0);
            if (mem_ack) mem_ack = 0;
            else if (mem_req) begin
                if (mem_we) begin
                    swb = 1; swb_a = mem_addr; swb_d = mem_wdata;
                end else begin
                    smrd++; mem_rdata = mem[mem_addr];
                end
                mem_ack = 1;
            end
            if (bus_valid) begin
                sv = 1; scmd = int'(bus_cmd);
                chk(bus_gnt == 1'b1, "R5", 32'(bus_gnt), 1);
                chk(bus_addr == a, rq, bus_addr, a);
            end
            if (sv && scmd != 1 && !inv_ack_all) begin
                chk(bus_req == 1'b1, "R7", 32'(bus_req), 1);
                invc++;
                if (invc == 3) inv_ack_all = 1;
            end
            if (bus_req && !bus_gnt) begin
                if (race && !raced) begin
                    raced = 1; snp_valid = 1; snp_cmd = 2'd3; snp_addr = a;
                end else begin
                    bus_gnt = 1;
                end
            end
            if (!bus_req) bus_gnt = 0;
            @(negedge clk);
        end
        bus_gnt = 0; mem_ack = 0; inv_ack_all = 0; snp_valid = 0;
        bus_shared_in = 0; bus_dirty_in = 0;
        chk(done, "watchdog", 32'(done), 1);
        chk(scmd == ecmd, rq, scmd, ecmd);
        chk(swb == ewb, "R8", 32'(swb), 32'(ewb));
        if (ewb) begin
            chk(swb_a == ewb_a, "R8", swb_a, ewb_a);
            chk(swb_d == ewb_d, "R8", swb_d, ewb_d);
        end
        if (!we) chk(srd == erd, rq, srd, erd);
        chk(smrd == emrd, rq, smrd, emrd);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < 8; i++) begin
            m_st[i] = 0; m_tag[i] = 0; m_dat[i] = 0;
        end
        for (int i = 0; i < 256; i++) mem[i] = 32'hC0DE_0000 | 32'(i);
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(cpu_ready == 1'b1, "R1", 32'(cpu_ready), 1);
        chk(bus_req == 1'b0, "R1", 32'(bus_req), 0);
        chk(mem_req == 1'b0, "R1", 32'(mem_req), 0);
        chk(cpu_resp_valid == 1'b0, "R1", 32'(cpu_resp_valid), 0);
        for (int i = 0; i < 8; i++) snoop_op(1, 8'(i), "R1");

        cpu_op(0, 8'h05, 0, 0, 0, 0, 0);                 // R3 fill Exclusive
        cpu_op(0, 8'h05, 0, 0, 0, 0, 0);                 // R2 hit
        cpu_op(1, 8'h05, 32'h1111_2222, 0, 0, 0, 0);     // R4 silent upgrade
        snoop_op(1, 8'h05, "");                          // R9 supply, to Shared
        cpu_op(1, 8'h05, 32'h3333_4444, 0, 0, 0, 0);     // R5 invalidate, R7
        snoop_op(1, 8'h0D, "");                          // R11 other tag
        cpu_op(0, 8'h05, 0, 0, 0, 0, 0);                 // R11 line kept: hit
        cpu_op(0, 8'h0D, 0, 1, 0, 0, 0);                 // R8 dirty victim, R3 Shared
        snoop_op(2, 8'h0D, "");                          // R10 invalidate
        cpu_op(0, 8'h0D, 0, 1, 1, 32'hDEAD_BEEF, 0);     // R3 cache-supplied fill
        cpu_op(1, 8'h13, 32'h5555_6666, 0, 0, 0, 0);     // R6 write miss
        cpu_op(0, 8'h1B, 0, 0, 0, 0, 0);                 // R8 write-back
        cpu_op(0, 8'h03, 0, 0, 0, 0, 0);                 // R8 clean victim dropped
        cpu_op(0, 8'h06, 0, 1, 0, 0, 0);                 // R3 Shared fill
        cpu_op(1, 8'h06, 32'h7777_8888, 0, 0, 0, 1);     // R12 lost upgrade
        snoop_op(3, 8'h06, "");                          // R10 no supply on Modified

        for (int i = 0; i < 300; i++) begin
            int r;
            logic [7:0] a;
            r = int'($urandom_range(0, 9));
            a = 8'($urandom_range(0, 31));
            if (r < 7)
                cpu_op(r < 3, a, $urandom, $urandom_range(0, 1) == 1,
                       $urandom_range(0, 3) == 0, $urandom, 0);
            else
                snoop_op(int'($urandom_range(1, 3)), a, "");
        end
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule